// File: doc/BRIEF.md
# Sub-Endpoint Control Register Bank

This block hangs off one endpoint of a datagram router and holds a small set of control registers. It stores no payload. Every datagram that reaches it opens with a LEB128-coded sub-endpoint number, and a small state machine acts on each byte as it arrives. If data bytes follow the number, they are written into the selected register, lowest byte first. If the number is the whole payload, the datagram is a read request. The block then answers with a fixed-length reply payload that it builds from the live register value, one byte per handshake.

One extra sub-endpoint does not hold a register. A datagram sent to it fires a single-cycle strobe. Surrounding logic can use that strobe to knock a waiting state machine out of its wait, for example to abort a transfer that has stalled. All other sub-endpoint numbers are drained and dropped, with no effect.

Top module: `subep_regbank`

## Requirements
- R1: After reset every register reads zero, `outValid` and `pokeStrobe` are low and `inReady` is high.
- R2: The sub-endpoint number is unsigned LEB128: bits 6:0 of each byte are appended at rising weight and bit 7 set means another byte follows. So the single byte 0x02 and the pair 0x82,0x00 both select sub-endpoint 2. Sub-endpoints 0 to 3 are registers 0 to 3.
- R3: In a write, the k-th byte after the sub-endpoint (k = 0..3) replaces bits 8k+7:8k of the selected register. It shows on `regOut` in the cycle after that byte is accepted.
- R4: A write that carries fewer than 4 data bytes leaves the register bytes it does not supply unchanged.
- R5: Data bytes after the fourth are accepted and have no effect on any register.
- R6: A datagram that holds only a register sub-endpoint is a read request. It produces a 4-byte reply on `outData`, least significant byte first, with `outLast` on the fourth byte and `outLen` equal to 4.
- R7: `inReady` is low exactly while a reply is pending. A reply byte holds its value while `outReady` is low.
- R8: Any datagram to sub-endpoint 4, whatever its length, raises `pokeStrobe` for exactly one cycle and changes no register.
- R9: A datagram to any other sub-endpoint, including a number too large for the decoder, is fully consumed. It changes no register and produces no reply.
- R10: Bit 7 of the first data byte has no command meaning. A write whose first data byte is 0x80 stores 0x80.
- R11: A datagram that ends while a sub-endpoint byte still has bit 7 set is dropped, and decoding of the next datagram starts fresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Incoming payload byte valid |
| inData | input | 8 | Incoming payload byte |
| inLast | input | 1 | Final byte of the incoming datagram |
| inReady | output | 1 | Block accepts an incoming byte |
| outValid | output | 1 | Reply byte valid |
| outData | output | 8 | Reply byte |
| outLast | output | 1 | Final reply byte |
| outLen | output | 8 | Reply payload length in bytes |
| outReady | input | 1 | Consumer takes the reply byte |
| regOut | output | 128 | All registers, register n at bits 32n+31:32n |
| pokeStrobe | output | 1 | One-cycle poke pulse |

## Verification
The bench targets the following corner cases:
- A padded two-byte sub-endpoint encoding. A decoder that treats each byte as a full number would address the wrong register.
- Writes that are too short or too long. A byte counter that wraps instead of saturating would overwrite the low bytes again.
- A first data byte with bit 7 set. A design that reads it as a direction flag would drop the write.
- A truncated sub-endpoint. If the decoder's accumulator is not cleared, the next read goes to the wrong register.
- A long poke datagram. A strobe raised per byte would pulse several times.
- Replies under random back-pressure. A design that advances on every cycle would skip bytes.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  typedef enum logic [1:0] {
    ST_SEL   = 2'd0,
    ST_DATA  = 2'd1,
    ST_REPLY = 2'd2
  } bankState_t;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_REG  = 2'd1,
    K_POKE = 2'd2
  } targetKind_t;

  typedef struct packed {
    logic wrEn;
    logic pokeFire;
  } bankStrobes_t;

endpackage

// File: rtl/regbank_leb.sv
module regbank_leb #(
  parameter int MAX_BYTES = 2,
  parameter int ACC_W     = 7 * MAX_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       inData,
  input  logic             accStep,
  input  logic             accClear,
  output logic [ACC_W-1:0] selNext,
  output logic             selOvf
);
  localparam int CNT_W = $clog2(MAX_BYTES + 1);

  logic [ACC_W-1:0] accQ;
  logic [CNT_W-1:0] cntQ;
  logic             ovfQ;

  // Fold the current byte into the running value without waiting a cycle.
  always_comb begin
    if (cntQ < CNT_W'(MAX_BYTES)) begin
      selNext = accQ | (ACC_W'(inData[6:0]) << (7 * int'(cntQ)));
      selOvf  = ovfQ;
    end else begin
      selNext = accQ;
      selOvf  = ovfQ | (inData[6:0] != 7'd0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || accClear) begin
      accQ <= '0;
      cntQ <= '0;
      ovfQ <= 1'b0;
    end else if (accStep) begin
      accQ <= selNext;
      ovfQ <= selOvf;
      if (cntQ < CNT_W'(MAX_BYTES)) cntQ <= cntQ + 1'b1;
    end
  end

  // R11
  leb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accClear |=> (accQ == '0) && !ovfQ);

endmodule

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
#(
  parameter int NUM_REGS   = 4,
  parameter int REG_BYTES  = 4,
  parameter int POKE_SUB   = 4,
  parameter int ACC_W      = 14,
  parameter int REG_IDX_W  = 2,
  parameter int CNT_W      = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inValid,
  input  logic                 inLast,
  input  logic                 contBit,
  input  logic [ACC_W-1:0]     selNext,
  input  logic                 selOvf,
  output logic                 inReady,
  output logic                 outValid,
  input  logic                 outReady,
  output logic                 outLast,
  output logic                 accStep,
  output logic                 accClear,
  output bankStrobes_t         strobes,
  output logic [REG_IDX_W-1:0] regIdx,
  output logic [CNT_W-1:0]     byteCnt
);
  bankState_t  stateQ;
  targetKind_t kindQ;
  logic        accept, selDone, isRegSel, isPokeSel;

  always_comb begin
    inReady   = (stateQ != ST_REPLY);
    outValid  = (stateQ == ST_REPLY);
    outLast   = outValid && (byteCnt == CNT_W'(REG_BYTES - 1));
    accept    = inValid && inReady;
    selDone   = accept && (stateQ == ST_SEL) && !contBit;
    isRegSel  = !selOvf && (selNext < ACC_W'(NUM_REGS));
    isPokeSel = !selOvf && (selNext == ACC_W'(POKE_SUB)) && !isRegSel;
    accStep   = accept && (stateQ == ST_SEL) && contBit && !inLast;
    accClear  = accept && (stateQ == ST_SEL) && (!contBit || inLast);
    strobes.pokeFire = selDone && isPokeSel;
    strobes.wrEn     = accept && (stateQ == ST_DATA) && (kindQ == K_REG)
                       && (byteCnt < CNT_W'(REG_BYTES));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ  <= ST_SEL;
      kindQ   <= K_NONE;
      regIdx  <= '0;
      byteCnt <= '0;
    end else begin
      unique case (stateQ)
        ST_SEL: if (selDone) begin
          regIdx  <= selNext[REG_IDX_W-1:0];
          byteCnt <= '0;
          kindQ   <= isRegSel ? K_REG : (isPokeSel ? K_POKE : K_NONE);
          if (!inLast)       stateQ <= ST_DATA;
          else if (isRegSel) stateQ <= ST_REPLY;
        end
        ST_DATA: if (accept) begin
          if (byteCnt < CNT_W'(REG_BYTES)) byteCnt <= byteCnt + 1'b1;
          if (inLast) stateQ <= ST_SEL;
        end
        ST_REPLY: if (outReady) begin
          if (outLast) stateQ <= ST_SEL;
          else         byteCnt <= byteCnt + 1'b1;
        end
        default: stateQ <= ST_SEL;
      endcase
    end
  end

  // R7
  reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> outValid && $stable(byteCnt) && $stable(regIdx));

  // R6
  reply_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outReady && outLast) |=> !outValid && inReady);

  // R5
  write_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.wrEn |=> (byteCnt <= CNT_W'(REG_BYTES)) && inReady);

endmodule

// File: rtl/regbank_data.sv
module regbank_data
  import regbank_pkg::*;
#(
  parameter int NUM_REGS   = 4,
  parameter int REG_BYTES  = 4,
  parameter int REG_IDX_W  = 2,
  parameter int BYTE_IDX_W = 2,
  parameter int REG_BITS   = 8 * REG_BYTES
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [7:0]                   inData,
  input  bankStrobes_t                 strobes,
  input  logic [REG_IDX_W-1:0]         regIdx,
  input  logic [BYTE_IDX_W-1:0]        byteIdx,
  output logic [7:0]                   outData,
  output logic [NUM_REGS*REG_BITS-1:0] regOut,
  output logic                         pokeStrobe
);
  logic [REG_BITS-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs[g] <= '0;
      end else if (strobes.wrEn && (regIdx == REG_IDX_W'(g))) begin
        regs[g][8*byteIdx +: 8] <= inData;
      end
    end
    assign regOut[g*REG_BITS +: REG_BITS] = regs[g];
  end

  assign outData = regs[regIdx][8*byteIdx +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) pokeStrobe <= 1'b0;
    else        pokeStrobe <= strobes.pokeFire;
  end

  // R9
  write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.wrEn |=> $stable(regOut));

  // R8
  poke_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pokeStrobe |-> $stable(regOut));

endmodule

// File: rtl/subep_regbank.sv
module subep_regbank
  import regbank_pkg::*;
#(
  parameter int NUM_REGS      = 4,
  parameter int REG_BYTES     = 4,
  parameter int SEL_MAX_BYTES = 2,
  parameter int POKE_SUB      = NUM_REGS,
  parameter int LEN_W         = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            inValid,
  input  logic [7:0]                      inData,
  input  logic                            inLast,
  output logic                            inReady,
  output logic                            outValid,
  output logic [7:0]                      outData,
  output logic                            outLast,
  output logic [LEN_W-1:0]                outLen,
  input  logic                            outReady,
  output logic [NUM_REGS*REG_BYTES*8-1:0] regOut,
  output logic                            pokeStrobe
);
  localparam int ACC_W      = 7 * SEL_MAX_BYTES;
  localparam int REG_IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int BYTE_IDX_W = (REG_BYTES > 1) ? $clog2(REG_BYTES) : 1;
  localparam int CNT_W      = $clog2(REG_BYTES + 1);

  logic [ACC_W-1:0]     selNext;
  logic                 selOvf, accStep, accClear;
  bankStrobes_t         strobes;
  logic [REG_IDX_W-1:0] regIdx;
  logic [CNT_W-1:0]     byteCnt;

  assign outLen = LEN_W'(REG_BYTES);

  regbank_leb #(.MAX_BYTES(SEL_MAX_BYTES), .ACC_W(ACC_W)) i_leb (
    .clk(clk), .rst_n(rst_n), .inData(inData),
    .accStep(accStep), .accClear(accClear),
    .selNext(selNext), .selOvf(selOvf)
  );

  regbank_ctrl #(
    .NUM_REGS(NUM_REGS), .REG_BYTES(REG_BYTES), .POKE_SUB(POKE_SUB),
    .ACC_W(ACC_W), .REG_IDX_W(REG_IDX_W), .CNT_W(CNT_W)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inLast(inLast),
    .contBit(inData[7]), .selNext(selNext), .selOvf(selOvf),
    .inReady(inReady), .outValid(outValid), .outReady(outReady),
    .outLast(outLast), .accStep(accStep), .accClear(accClear),
    .strobes(strobes), .regIdx(regIdx), .byteCnt(byteCnt)
  );

  regbank_data #(
    .NUM_REGS(NUM_REGS), .REG_BYTES(REG_BYTES),
    .REG_IDX_W(REG_IDX_W), .BYTE_IDX_W(BYTE_IDX_W)
  ) i_data (
    .clk(clk), .rst_n(rst_n), .inData(inData), .strobes(strobes),
    .regIdx(regIdx), .byteIdx(byteCnt[BYTE_IDX_W-1:0]),
    .outData(outData), .regOut(regOut), .pokeStrobe(pokeStrobe)
  );

endmodule

// File: tb/test_subep_regbank.sv
module test_subep_regbank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0, inLast = 1'b0, outReady = 1'b0;
  logic [7:0] inData = 8'h00;
  logic inReady, outValid, outLast, pokeStrobe;
  logic [7:0] outData, outLen;
  logic [127:0] regOut;

  int total = 0, bad = 0, pokeSeen = 0, pokeExp = 0;
  bit finished = 0;
  logic [31:0] model [4];

  always #2 clk = ~clk;

  subep_regbank i_subep_regbank (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inData(inData),
    .inLast(inLast), .inReady(inReady), .outValid(outValid),
    .outData(outData), .outLast(outLast), .outLen(outLen),
    .outReady(outReady), .regOut(regOut), .pokeStrobe(pokeStrobe)
  );

  always @(posedge clk) if (rst_n && pokeStrobe) pokeSeen++;

  function automatic logic [127:0] modelFlat();
    return {model[3], model[2], model[1], model[0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the byte is taken.
  task automatic putByte(input logic [7:0] b, input bit last);
    inValid = 1'b1; inData = b; inLast = last;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic putSel(input int sub, input bit padded, input bit lastOnSel);
    if (sub > 127) begin
      putByte(8'hFF, 0); putByte(8'hFF, 0); putByte(8'h7F, lastOnSel);
    end else if (padded) begin
      putByte(8'h80 | 8'(sub), 0); putByte(8'h00, lastOnSel);
    end else begin
      putByte(8'(sub), lastOnSel);
    end
  endtask

  task automatic checkPokes(input string req);
    @(negedge clk); @(negedge clk);
    chk(pokeSeen == pokeExp, req, 128'(pokeSeen), 128'(pokeExp));
  endtask

  task automatic doWrite(input int sub, input int n, input bit padded,
                         input logic [7:0] firstByte, input bit useFirst);
    putSel(sub, padded, 0);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = (i == 0 && useFirst) ? firstByte : 8'($urandom);
      putByte(b, i == n - 1);
      if (sub < 4 && i < 4) model[sub][8*i +: 8] = b;
      // R3 R4 R5 R9: each byte visible the cycle after acceptance
      chk(regOut == modelFlat(), (sub < 4) ? "R3/R4/R5" : "R9", regOut, modelFlat());
    end
    if (sub == 4) pokeExp++;
    checkPokes("R8");
  endtask

  task automatic doRead(input int sub, input bit padded);
    putSel(sub, padded, 1);
    if (sub < 4) begin
      int idx = 0;
      int guard = 0;
      while (idx < 4 && guard < 200) begin
        guard++;
        outReady = ($urandom % 3) != 0;
        chk(outValid == 1'b1 && inReady == 1'b0, "R7", {outValid, inReady}, 2'b10);
        chk(outData == model[sub][8*idx +: 8], "R6", outData, model[sub][8*idx +: 8]);
        chk(outLast == (idx == 3) && outLen == 8'd4, "R6", {outLast, outLen},
            {1'(idx == 3), 8'd4});
        if (outReady) idx++;
        @(negedge clk);
      end
      outReady = 1'b0;
      chk(outValid == 1'b0 && inReady == 1'b1, "R7", {outValid, inReady}, 2'b01);
    end else begin
      @(negedge clk);
      chk(outValid == 1'b0 && inReady == 1'b1, "R9", {outValid, inReady}, 2'b01);
    end
    if (sub == 4) pokeExp++;
    checkPokes("R8");
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EB1));
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(regOut == '0, "R1", regOut, '0);
    chk(outValid == 0 && pokeStrobe == 0 && inReady == 1, "R1",
        {outValid, pokeStrobe, inReady}, 3'b001);

    doWrite(1, 4, 0, 8'h11, 1);               // R3 full write
    doWrite(1, 2, 0, 8'hAA, 1);               // R4 partial
    doWrite(2, 7, 0, 8'h5A, 1);               // R5 overlong
    doWrite(3, 2, 0, 8'h80, 1);               // R10 first byte 0x80
    chk(regOut[103:96] == 8'h80, "R10", regOut[103:96], 8'h80);
    doWrite(0, 3, 1, 8'h00, 0);               // R2 padded selector
    doRead(1, 0);                             // R6 R7
    doRead(2, 1);                             // R2 padded read
    doRead(4, 0);                             // R8 poke, sub-endpoint only
    doWrite(4, 5, 0, 8'h00, 0);               // R8 long poke: one pulse
    doWrite(6, 3, 0, 8'h00, 0);               // R9 unknown
    doWrite(200, 4, 0, 8'h00, 0);             // R9 oversized number
    doRead(5, 0);                             // R9 no reply
    putByte(8'h81, 1);                        // R11 truncated selector
    chk(outValid == 1'b0 && regOut == modelFlat(), "R11", regOut, modelFlat());
    doRead(2, 0);                             // R11 fresh decode -> reg 2

    for (int it = 0; it < 300; it++) begin
      int sub = $urandom % 7;
      bit padded = ($urandom % 4) == 0;
      if ($urandom % 3 == 0) doRead(sub, padded);
      else doWrite(sub, 1 + ($urandom % 6), padded, 8'h00, 0);
    end
    doRead(0, 0); doRead(3, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule